// File: doc/BRIEF.md
# Dual-Core Power Mode Controller

This block keeps track of the power state of two processor cores and of the system around them. Each core moves between running and sleeping on its own. A core enters sleep when it executes a wait-for-interrupt or wait-for-event. It returns to running when it takes an interrupt. A sleeping core has its clock gated, while peripherals and memories stay powered and clocked.

A core that is allowed to take part in system power-down can attach a request for one of three system modes to its wait instruction: deep-sleep, power-down or deep power-down. The system enters a power-down mode only when every allowed core holds such a request. If the requests differ, the shallowest mode wins. In any power-down mode, all core clocks and the peripheral domain are switched off. Memory power is kept in deep-sleep and power-down and dropped in deep power-down. An always-on wake event returns the system to run, with both cores running and all requests cleared.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, `sys_mode_o` is 0 (run), both bits of `core_clk_en_o` are 1, and `periph_pwr_en_o` and `mem_pwr_en_o` are 1.
- R2: In run mode, a wait pulse on a running core clears that core's clock enable one cycle later. An interrupt on a sleeping core sets it again one cycle later. The other core is unaffected, a wait on an already sleeping core is ignored, and an interrupt wins over a wait in the same cycle.
- R3: A wait records a pending power-down request only if the core's `pd_allow_i` bit is 1 and its 2-bit selection `pd_sel_i[2*i+1:2*i]` is non-zero. Otherwise the wait is a plain sleep and never starts a power-down.
- R4: Mode codes are 0 run, 1 deep-sleep, 2 power-down and 3 deep power-down. The system leaves run one cycle after the edge on which every allowed core holds a request, provided at least one core is allowed.
- R5: When the allowed cores request different modes, the mode entered is the smallest non-zero code among them (the shallowest).
- R6: In every power-down mode, `core_clk_en_o` is 0 and `periph_pwr_en_o` is 0. In run mode, `periph_pwr_en_o` is 1.
- R7: `mem_pwr_en_o` is 1 in run, deep-sleep and power-down, and 0 in deep power-down.
- R8: An interrupt to a core with a pending request clears that request. If the interrupt comes in the cycle in which entry would occur, the entry is aborted.
- R9: `wake_i` in a power-down mode returns the system to run one cycle later, with both cores running and no requests pending. `wake_i` in run mode has no effect.
- R10: In a power-down mode, wait and interrupt inputs are ignored, and the mode is held until `wake_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_wait_i | input | NCORE | Per-core wait-for-interrupt/event pulse |
| core_irq_i | input | NCORE | Per-core interrupt taken |
| pd_allow_i | input | NCORE | Core is allowed to request system power-down |
| pd_sel_i | input | 2*NCORE | Per-core requested mode, 2 bits per core, 0 means none |
| wake_i | input | 1 | Always-on wake event |
| core_clk_en_o | output | NCORE | Per-core clock enable |
| periph_pwr_en_o | output | 1 | Peripheral domain power enable |
| mem_pwr_en_o | output | 1 | Memory power / retention enable |
| sys_mode_o | output | 2 | System mode code |

## Verification
Every result is registered once. A clock enable changes one edge after its wait or interrupt, and a mode change appears one edge after the last request is recorded or after the wake event. An entry that needs two waits therefore shows up two edges after the first wait. The bench drives inputs one time unit after a rising edge. It advances its own reference state at the next edge and compares all outputs one time unit after that edge, so each expected value is sampled in exactly the cycle it is due. Directed sequences add explicit checks at those same sample points for mixed requests, aborted entry, deep power-down and wake.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int NCORE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCORE-1:0]   core_wait_i,
  input  logic [NCORE-1:0]   core_irq_i,
  input  logic [NCORE-1:0]   pd_allow_i,
  input  logic [2*NCORE-1:0] pd_sel_i,
  input  logic               wake_i,
  output logic [NCORE-1:0]   core_clk_en_o,
  output logic               periph_pwr_en_o,
  output logic               mem_pwr_en_o,
  output logic [1:0]         sys_mode_o
);
  localparam logic [1:0] M_RUN = 2'd0;
  localparam logic [1:0] M_DPD = 2'd3;

  logic [1:0]       mode_q;
  logic [NCORE-1:0] asleep_q, pend_q;
  logic [1:0]       sel_q [NCORE];
  logic             running, all_ready, any_ready;
  logic [1:0]       tgt;

  assign running = (mode_q == M_RUN);

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        asleep_q[i] <= 1'b0;
        pend_q[i]   <= 1'b0;
        sel_q[i]    <= 2'd0;
      end else if (!running) begin
        if (wake_i) begin
          asleep_q[i] <= 1'b0;
          pend_q[i]   <= 1'b0;
        end
      end else if (core_irq_i[i]) begin
        asleep_q[i] <= 1'b0;
        pend_q[i]   <= 1'b0;
      end else if (core_wait_i[i] && !asleep_q[i]) begin
        asleep_q[i] <= 1'b1;
        pend_q[i]   <= pd_allow_i[i] && (pd_sel_i[2*i +: 2] != 2'd0);
        sel_q[i]    <= pd_sel_i[2*i +: 2];
      end
    end
  end

  always_comb begin
    all_ready = 1'b1;
    any_ready = 1'b0;
    tgt       = M_DPD;
    for (int k = 0; k < NCORE; k++) begin
      if (pd_allow_i[k]) begin
        if (!pend_q[k] || core_irq_i[k]) all_ready = 1'b0;
        else begin
          any_ready = 1'b1;
          if (sel_q[k] < tgt) tgt = sel_q[k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_RUN;
    else if (running && all_ready && any_ready) mode_q <= tgt;
    else if (!running && wake_i) mode_q <= M_RUN;
  end

  assign core_clk_en_o   = running ? ~asleep_q : '0;
  assign periph_pwr_en_o = running;
  assign mem_pwr_en_o    = (mode_q != M_DPD);
  assign sys_mode_o      = mode_q;
endmodule

module pwr_mode_ctrl_chk #(
  parameter int NCORE = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCORE-1:0]   core_irq_i,
  input logic [NCORE-1:0]   core_wait_i,
  input logic [NCORE-1:0]   pd_allow_i,
  input logic               wake_i,
  input logic [NCORE-1:0]   core_clk_en_o,
  input logic               periph_pwr_en_o,
  input logic [1:0]         sys_mode_o
);
  assert_down_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode_o != 2'd0) |-> (core_clk_en_o == '0 && !periph_pwr_en_o));

  assert_wake_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode_o != 2'd0 && wake_i) |=> (sys_mode_o == 2'd0 && core_clk_en_o == '1));

  assert_down_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode_o != 2'd0 && !wake_i) |=> $stable(sys_mode_o));

  assert_entry_needs_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode_o == 2'd0 && (pd_allow_i & core_clk_en_o) != '0) |=> (sys_mode_o == 2'd0));

  assert_irq_wakes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode_o == 2'd0 && core_irq_i != '0) |=>
      (sys_mode_o != 2'd0 || (core_clk_en_o & $past(core_irq_i)) == $past(core_irq_i)));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_irq_i(core_irq_i), .core_wait_i(core_wait_i),
  .pd_allow_i(pd_allow_i), .wake_i(wake_i), .core_clk_en_o(core_clk_en_o),
  .periph_pwr_en_o(periph_pwr_en_o), .sys_mode_o(sys_mode_o)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] wt = '0, irq = '0, allow = '0;
  logic [2*NC-1:0] sel = '0;
  logic wake = 1'b0;
  logic [NC-1:0] clk_en;
  logic periph, mem;
  logic [1:0] mode;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [1:0] m_mode;
  logic [NC-1:0] m_asleep, m_pend;
  logic [1:0] m_sel [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.NCORE(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_wait_i(wt), .core_irq_i(irq),
    .pd_allow_i(allow), .pd_sel_i(sel), .wake_i(wake),
    .core_clk_en_o(clk_en), .periph_pwr_en_o(periph),
    .mem_pwr_en_o(mem), .sys_mode_o(mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] exp_clk();
    return (m_mode == 2'd0) ? ~m_asleep : '0;
  endfunction

  function automatic logic exp_mem();
    return m_mode != 2'd3;
  endfunction

  task automatic compare_all();
    chk(clk_en == exp_clk(), "R2 clock enables", clk_en, exp_clk());
    chk(periph == (m_mode == 2'd0), "R6 peripheral power", periph, m_mode == 2'd0);
    chk(mem == exp_mem(), "R7 memory power", mem, exp_mem());
    chk(mode == m_mode, "R4 system mode", mode, m_mode);
  endtask

  task automatic model_reset();
    m_mode = 2'd0; m_asleep = '0; m_pend = '0;
    for (int k = 0; k < NC; k++) m_sel[k] = 2'd0;
  endtask

  task automatic tick();
    logic [1:0] n_mode;
    logic [NC-1:0] n_asleep, n_pend;
    logic [1:0] n_sel [NC];
    logic all_r, any_r;
    logic [1:0] t;
    n_mode = m_mode; n_asleep = m_asleep; n_pend = m_pend;
    for (int k = 0; k < NC; k++) n_sel[k] = m_sel[k];
    all_r = 1'b1; any_r = 1'b0; t = 2'd3;
    if (m_mode != 2'd0) begin
      if (wake) begin n_mode = 2'd0; n_asleep = '0; n_pend = '0; end
    end else begin
      for (int k = 0; k < NC; k++) begin
        if (irq[k]) begin n_asleep[k] = 1'b0; n_pend[k] = 1'b0; end
        else if (wt[k] && !m_asleep[k]) begin
          n_asleep[k] = 1'b1;
          n_pend[k] = allow[k] && sel[2*k +: 2] != 2'd0;
          n_sel[k] = sel[2*k +: 2];
        end
        if (allow[k]) begin
          if (!m_pend[k] || irq[k]) all_r = 1'b0;
          else begin any_r = 1'b1; if (m_sel[k] < t) t = m_sel[k]; end
        end
      end
      if (all_r && any_r) n_mode = t;
    end
    @(posedge clk);
    #1;
    m_mode = n_mode; m_asleep = n_asleep; m_pend = n_pend;
    for (int k = 0; k < NC; k++) m_sel[k] = n_sel[k];
    compare_all();
  endtask

  task automatic idle();
    wt = '0; irq = '0; wake = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(mode == 2'd0 && clk_en == 2'b11 && periph && mem, "R1 reset state",
        {mode, clk_en, periph, mem}, 6'b001111);

    // R5: core0 asks power-down, core1 deep-sleep; shallower one wins
    allow = 2'b11; sel = {2'd1, 2'd2};
    wt = 2'b01; tick(); idle();
    chk(clk_en == 2'b10, "R2 core0 asleep alone", clk_en, 2);
    tick();
    chk(mode == 2'd0, "R4 one core pending only", mode, 0);
    wt = 2'b10; tick(); idle();
    chk(mode == 2'd0, "R4 not yet entered", mode, 0);
    tick();
    chk(mode == 2'd1, "R5 shallower mode", mode, 1);
    wt = 2'b11; irq = 2'b11; tick(); idle();
    chk(mode == 2'd1, "R10 inputs ignored when down", mode, 1);
    wake = 1'b1; tick(); idle();
    chk(mode == 2'd0 && clk_en == 2'b11, "R9 wake restores", {mode, clk_en}, 3);
    wake = 1'b1; tick(); idle();
    chk(mode == 2'd0 && clk_en == 2'b11, "R9 wake in run no effect", {mode, clk_en}, 3);
    tick();
    chk(mode == 2'd0, "R9 requests cleared by wake", mode, 0);

    // R8: interrupt aborts entry in the entry cycle
    sel = {2'd3, 2'd3};
    wt = 2'b11; tick(); idle();
    irq = 2'b01; tick(); idle();
    chk(mode == 2'd0 && clk_en == 2'b01, "R8 abort by interrupt", {mode, clk_en}, 1);
    repeat (3) tick();
    chk(mode == 2'd0, "R8 request stays cleared", mode, 0);
    irq = 2'b10; tick(); idle();

    // R7: deep power-down with only core0 allowed, core1 keeps running
    allow = 2'b01; sel = {2'd0, 2'd3};
    wt = 2'b01; tick(); idle();
    tick();
    chk(mode == 2'd3 && !mem && !periph, "R7 deep power-down drops memory",
        {mode, mem, periph}, 12);
    chk(clk_en == 2'b00, "R6 all clocks off when down", clk_en, 0);
    wake = 1'b1; tick(); idle();

    // R3: allowed core with no selection only sleeps
    allow = 2'b01; sel = '0;
    wt = 2'b01; tick(); idle();
    repeat (2) tick();
    chk(mode == 2'd0 && clk_en == 2'b10, "R3 plain sleep", {mode, clk_en}, 2);
    irq = 2'b01; tick(); idle();

    // R3: request from a core that is not allowed is ignored
    allow = 2'b10; sel = {2'd0, 2'd2};
    wt = 2'b01; tick(); idle();
    repeat (2) tick();
    chk(mode == 2'd0, "R3 disallowed core request ignored", mode, 0);
    irq = 2'b01; tick(); idle();

    // power-down mode, memory kept
    allow = 2'b10; sel = {2'd2, 2'd0};
    wt = 2'b10; tick(); idle(); tick();
    chk(mode == 2'd2 && mem, "R7 power-down keeps memory", {mode, mem}, 5);
    wake = 1'b1; tick(); idle();

    // constrained random
    void'($urandom(32'h0bad_c0de));
    for (int n = 0; n < 6000; n++) begin
      wt = $urandom_range(0, 3) == 0 ? NC'($urandom) : '0;
      irq = $urandom_range(0, 7) == 0 ? NC'($urandom) : '0;
      wake = $urandom_range(0, 5) == 0;
      if ($urandom_range(0, 15) == 0) allow = NC'($urandom);
      if ($urandom_range(0, 7) == 0) sel = (2*NC)'($urandom);
      tick();
    end
    idle();
    finish_run();
  end
endmodule